// File: doc/BRIEF.md
# Packet Header Address Filter

This block decides whether a received packet is meant for this node by checking the header bytes that follow sync detection. A deserializer hands it one header byte at a time. A single-cycle start pulse at sync detection arms the block and captures the configuration. As each header byte arrives, the block judges whether that byte passes.

A byte is compared bit by bit against its expected value, and only the bits selected by a per-bit mask count. A byte can also pass as a broadcast address, where the masked bits are all ones. Positions whose check enable is clear always pass. Once the configured number of header bytes has arrived, the block issues exactly one accept or reject strobe. An abort returns the block to idle without a verdict.

The header length, the per-byte check and broadcast enables, the expected header word and the bit mask are all plain input ports. They are sampled at the start pulse.

Top module: `hdr_addr_filter`

## Requirements
- R1: After reset `busy`, `acceptPulse` and `rejectPulse` are low.
- R2: All configuration inputs are sampled in the cycle of `startPulse`. Changes to them while a packet is being received have no effect on its verdict.
- R3: `cfgLen` holds the header length minus one (0 means 1 byte, 3 means 4 bytes). Received bytes fill header positions from 3 downward. Position p uses bits [8p+7:8p] of `cfgExpect` and `cfgBitMask`, and bit p of `cfgCheckEn` and `cfgBcastEn`. Positions below 4-N are not checked.
- R4: A position whose `cfgCheckEn` bit is 0 always passes, whatever byte arrives for it.
- R5: Only the bits set in `cfgBitMask` take part in the comparison. A difference in a masked-off bit never causes a failure.
- R6: With the `cfgBcastEn` bit of a position set, a byte also passes when all of its masked bits are 1.
- R7: The strobe appears in the cycle after the N-th byte is taken and lasts one cycle. `acceptPulse` is raised when every checked position passed; otherwise `rejectPulse` is raised. The two are never high together.
- R8: `abortPulse` returns the block to idle and suppresses any strobe for the packet. It wins over a `startPulse` in the same cycle.
- R9: `byteValid` has no effect while the block is idle, including bytes that arrive after the verdict.
- R10: A `startPulse` while a packet is in progress restarts reception from header position 3, with new configuration and cleared results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Sync detected: arm the block and sample the configuration |
| abortPulse | input | 1 | Drop the current packet, return to idle |
| byteValid | input | 1 | A header byte is present on byteData |
| byteData | input | 8 | Received header byte |
| cfgLen | input | 2 | Header length minus one |
| cfgCheckEn | input | 4 | Per-position check enable |
| cfgBcastEn | input | 4 | Per-position broadcast enable |
| cfgExpect | input | 32 | Expected header value, one byte per position |
| cfgBitMask | input | 32 | Per-bit compare enable |
| acceptPulse | output | 1 | One-cycle strobe: header passed |
| rejectPulse | output | 1 | One-cycle strobe: header failed |
| busy | output | 1 | A packet header is being received |

## Verification
The bench builds the block with its default 8-bit bytes and four header positions. At that size, every combination of header length, check-enable mask and broadcast mask can be swept. Each combination is tried with four byte patterns: an exact match, all ones, a flip in a bit that is masked off in one position, and a flip in a compared bit. The verdict is predicted by a bitwise reference model in the bench. This reaches every path by which a position can pass or fail, and shows that positions beyond the length are ignored. Directed cases cover configuration changes during a packet, aborts, restarts and bytes that arrive while the block is idle.

// File: rtl/hdr_filt_pkg.sv
package hdr_filt_pkg;
  localparam int BYTE_W  = 8;
  localparam int NUM_HDR = 4;
  localparam int POS_W   = $clog2(NUM_HDR);

  // Strobes from control to datapath
  typedef struct packed {
    logic             loadCfg;
    logic             clearRes;
    logic             captureByte;
    logic [POS_W-1:0] pos;
  } ctrlStrobe_t;

  typedef enum logic {ST_IDLE, ST_RECV} filtState_t;
endpackage

// File: rtl/hdr_filt_ctrl.sv
module hdr_filt_ctrl
  import hdr_filt_pkg::*;
#(
  parameter int NHDR = NUM_HDR,
  localparam int PW = $clog2(NHDR),
  localparam int CW = $clog2(NHDR + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startPulse,
  input  logic          abortPulse,
  input  logic          byteValid,
  input  logic [PW-1:0] cfgLen,
  input  logic          allPass,
  output ctrlStrobe_t   ctrl,
  output logic          acceptPulse,
  output logic          rejectPulse,
  output logic          busy
);
  filtState_t    stateQ;
  logic [CW-1:0] cntQ;
  logic [PW-1:0] lenQ;
  logic          doneQ;
  logic          takeByte;
  logic          lastByte;
  logic          startOk;

  assign startOk  = startPulse && !abortPulse;
  assign takeByte = (stateQ == ST_RECV) && byteValid && !abortPulse && !startPulse;
  assign lastByte = takeByte && (cntQ == CW'(lenQ));

  always_comb begin
    ctrl.loadCfg     = startOk;
    ctrl.clearRes    = startOk;
    ctrl.captureByte = takeByte;
    ctrl.pos         = PW'(NHDR - 1) - cntQ[PW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      lenQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (abortPulse) begin
        stateQ <= ST_IDLE;
        cntQ   <= '0;
      end else if (startPulse) begin
        stateQ <= ST_RECV;
        cntQ   <= '0;
        lenQ   <= cfgLen;
      end else if (takeByte) begin
        cntQ <= cntQ + CW'(1);
        if (lastByte) begin
          stateQ <= ST_IDLE;
          doneQ  <= 1'b1;
        end
      end
    end
  end

  assign busy        = (stateQ == ST_RECV);
  assign acceptPulse = doneQ && allPass;
  assign rejectPulse = doneQ && !allPass;

  // R7
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptPulse && rejectPulse));
  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptPulse || rejectPulse) |=> !(acceptPulse || rejectPulse));
  // R8
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !(acceptPulse || rejectPulse || busy));
  // R10
  start_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !abortPulse) |=> busy);
  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CW'(NHDR));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startPulse) |=> !(acceptPulse || rejectPulse || busy));
endmodule

// File: rtl/hdr_filt_dp.sv
module hdr_filt_dp
  import hdr_filt_pkg::*;
#(
  parameter int BW   = BYTE_W,
  parameter int NHDR = NUM_HDR,
  localparam int WW = BW * NHDR
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     ctrl,
  input  logic [BW-1:0]   byteData,
  input  logic [NHDR-1:0] cfgCheckEn,
  input  logic [NHDR-1:0] cfgBcastEn,
  input  logic [WW-1:0]   cfgExpect,
  input  logic [WW-1:0]   cfgBitMask,
  output logic            allPass
);
  logic [WW-1:0]   expQ;
  logic [WW-1:0]   maskQ;
  logic [NHDR-1:0] enQ;
  logic [NHDR-1:0] bcQ;
  logic [NHDR-1:0] passVec;
  logic [NHDR-1:0] posPass;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expQ  <= '0;
      maskQ <= '0;
      enQ   <= '0;
      bcQ   <= '0;
    end else if (ctrl.loadCfg) begin
      expQ  <= cfgExpect;
      maskQ <= cfgBitMask;
      enQ   <= cfgCheckEn;
      bcQ   <= cfgBcastEn;
    end
  end

  for (genvar i = 0; i < NHDR; i++) begin : g_pos
    logic [BW-1:0] expB;
    logic [BW-1:0] mskB;
    logic          hit;
    logic          bcHit;
    assign expB  = expQ[i*BW +: BW];
    assign mskB  = maskQ[i*BW +: BW];
    assign hit   = &((byteData ~^ expB) | ~mskB);
    assign bcHit = bcQ[i] && (&(byteData | ~mskB));
    assign posPass[i] = !enQ[i] || hit || bcHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      passVec <= '1;
    end else if (ctrl.clearRes) begin
      passVec <= '1;
    end else if (ctrl.captureByte) begin
      passVec[ctrl.pos] <= posPass[ctrl.pos];
    end
  end

  assign allPass = &passVec;

  // R9
  hold_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.captureByte && !ctrl.clearRes) |=> $stable(passVec));
  // R4
  disabled_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.captureByte && !enQ[ctrl.pos]) |=> passVec[$past(ctrl.pos)]);
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.loadCfg |=> ($stable(expQ) && $stable(maskQ) && $stable(enQ) && $stable(bcQ)));
endmodule

// File: rtl/hdr_addr_filter.sv
module hdr_addr_filter
  import hdr_filt_pkg::*;
#(
  parameter int BW   = BYTE_W,
  parameter int NHDR = NUM_HDR,
  localparam int PW = $clog2(NHDR),
  localparam int WW = BW * NHDR
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic            abortPulse,
  input  logic            byteValid,
  input  logic [BW-1:0]   byteData,
  input  logic [PW-1:0]   cfgLen,
  input  logic [NHDR-1:0] cfgCheckEn,
  input  logic [NHDR-1:0] cfgBcastEn,
  input  logic [WW-1:0]   cfgExpect,
  input  logic [WW-1:0]   cfgBitMask,
  output logic            acceptPulse,
  output logic            rejectPulse,
  output logic            busy
);
  ctrlStrobe_t ctrl;
  logic        allPass;

  hdr_filt_ctrl #(.NHDR(NHDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .abortPulse(abortPulse),
    .byteValid(byteValid), .cfgLen(cfgLen), .allPass(allPass), .ctrl(ctrl),
    .acceptPulse(acceptPulse), .rejectPulse(rejectPulse), .busy(busy)
  );

  hdr_filt_dp #(.BW(BW), .NHDR(NHDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .byteData(byteData),
    .cfgCheckEn(cfgCheckEn), .cfgBcastEn(cfgBcastEn), .cfgExpect(cfgExpect),
    .cfgBitMask(cfgBitMask), .allPass(allPass)
  );
endmodule

// File: tb/hdr_addr_filter_tb.sv
module hdr_addr_filter_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        startPulse, abortPulse, byteValid;
  logic [7:0]  byteData;
  logic [1:0]  cfgLen;
  logic [3:0]  cfgCheckEn, cfgBcastEn;
  logic [31:0] cfgExpect, cfgBitMask;
  logic        acceptPulse, rejectPulse, busy;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  hdr_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .abortPulse(abortPulse),
    .byteValid(byteValid), .byteData(byteData), .cfgLen(cfgLen),
    .cfgCheckEn(cfgCheckEn), .cfgBcastEn(cfgBcastEn), .cfgExpect(cfgExpect),
    .cfgBitMask(cfgBitMask), .acceptPulse(acceptPulse), .rejectPulse(rejectPulse),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit refAccept(input int n, input logic [3:0] en, input logic [3:0] bc,
                                   input logic [31:0] ex, input logic [31:0] mk,
                                   input logic [31:0] rx);
    bit ok = 1;
    for (int p = 3; p >= 4 - n; p--) begin
      bit eq = 1;
      bit allOne = 1;
      for (int k = 0; k < 8; k++) begin
        int idx = p * 8 + k;
        if (mk[idx] && rx[idx] != ex[idx]) eq = 0;
        if (mk[idx] && !rx[idx]) allOne = 0;
      end
      if (en[p] && !(eq || (bc[p] && allOne))) ok = 0;
    end
    return ok;
  endfunction

  // strobe word: {accept, reject, busy}
  function automatic int outs();
    return {29'd0, acceptPulse, rejectPulse, busy};
  endfunction

  task automatic doStart();
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  // sends n bytes (rx, position 3 first); leaves the sim at the strobe cycle
  task automatic sendBytes(input int n, input logic [31:0] rx);
    for (int i = 0; i < n; i++) begin
      byteData  = rx[(3 - i) * 8 +: 8];
      byteValid = 1'b1;
      @(negedge clk);
    end
    byteValid = 1'b0;
  endtask

  task automatic runPacket(input int n, input logic [31:0] rx, input string req);
    bit exp;
    cfgLen = 2'(n - 1);
    exp = refAccept(n, cfgCheckEn, cfgBcastEn, cfgExpect, cfgBitMask, rx);
    doStart();
    sendBytes(n, rx);
    chk(acceptPulse == exp && rejectPulse == !exp, req, outs(), {exp, !exp, 1'b0});
    @(negedge clk);
    chk(outs() == 0, "R7 strobe one cycle", outs(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] ex, mk, rx;
    rstN = 0; startPulse = 0; abortPulse = 0; byteValid = 0; byteData = 0;
    cfgLen = 3; cfgCheckEn = 4'hF; cfgBcastEn = 0;
    ex = 32'hA53C_107E; mk = 32'hFF0F_F0FF;
    cfgExpect = ex; cfgBitMask = mk;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(outs() == 0, "R1 reset state", outs(), 0);

    // R9: bytes while idle do nothing
    for (int i = 0; i < 6; i++) begin
      byteValid = 1'b1; byteData = 8'(i * 37);
      @(negedge clk);
      chk(outs() == 0, "R9 idle bytes", outs(), 0);
    end
    byteValid = 0;

    // R3 R4 R5 R6 R7: sweep
    for (int n = 1; n <= 4; n++)
      for (int en = 0; en < 16; en++)
        for (int bc = 0; bc < 16; bc++)
          for (int v = 0; v < 4; v++) begin
            for (int p = 0; p < 4; p++) begin
              logic [7:0] e = ex[p * 8 +: 8];
              case ((v + p + en) % 4)
                0: rx[p * 8 +: 8] = e;
                1: rx[p * 8 +: 8] = 8'hFF;
                2: rx[p * 8 +: 8] = e ^ 8'h40;
                default: rx[p * 8 +: 8] = e ^ 8'h01;
              endcase
            end
            cfgCheckEn = 4'(en); cfgBcastEn = 4'(bc);
            runPacket(n, rx, "R3/R4/R5/R6/R7 sweep");
          end

    // R5: zero mask passes anything
    cfgCheckEn = 4'hF; cfgBcastEn = 0; cfgBitMask = 0;
    runPacket(4, 32'h1234_5678, "R5 empty mask");
    cfgBitMask = mk;

    // R2: config changes after start ignored
    cfgLen = 3; cfgCheckEn = 4'hF; cfgBcastEn = 0; cfgExpect = ex;
    doStart();
    cfgExpect = ~ex; cfgCheckEn = 4'hF; cfgLen = 0; cfgBitMask = 32'hFFFF_FFFF;
    sendBytes(4, ex);
    chk(acceptPulse && !rejectPulse, "R2 config held", outs(), 3'b100);
    @(negedge clk);
    cfgExpect = ex; cfgBitMask = mk;

    // R8: abort mid-packet
    cfgLen = 3;
    doStart();
    sendBytes(2, ex);
    abortPulse = 1'b1;
    @(negedge clk);
    abortPulse = 1'b0;
    chk(outs() == 0, "R8 abort to idle", outs(), 0);
    sendBytes(2, {ex[15:0], 16'h0});
    chk(outs() == 0, "R8 no strobe after abort", outs(), 0);
    @(negedge clk);
    chk(outs() == 0, "R8 still quiet", outs(), 0);

    // R8: abort wins over start
    @(negedge clk);
    startPulse = 1; abortPulse = 1;
    @(negedge clk);
    startPulse = 0; abortPulse = 0;
    chk(outs() == 0, "R8 abort beats start", outs(), 0);

    // R10: restart mid-packet clears failed results
    cfgLen = 3;
    doStart();
    sendBytes(2, ~ex);
    chk(busy == 1'b1, "R10 busy mid packet", outs(), 1);
    runPacket(4, ex, "R10 restart accepts");

    // R9: bytes after verdict ignored
    sendBytes(3, ex);
    chk(outs() == 0, "R9 bytes after verdict", outs(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule